// File: doc/BRIEF.md
# PPS-Referenced Oscillator Cycle Counter

This block measures the frequency of the clock it runs on against a one-pulse-per-second timing reference. A free-running cycle counter advances on every clock after reset and is never stopped, cleared or gated again. Each per-second result is the modular difference between two snapshots of that counter, so no clock cycle is lost between one measurement interval and the next.

Each synchronized rising edge of the reference produces one per-second count. The same per-second counts also feed a set of long-interval totals whose lengths grow by a fixed ratio. With the default ratio of 10 these cover 10, 100, 1000 and 10000 seconds. Each total comes out with a one-cycle strobe when its interval completes, and then starts again from zero. A timeout flag shows that the reference has gone quiet. At the nominal 50 MHz clock a stable oscillator gives per-second counts that vary by about one count from second to second, because the reference pulse itself jitters.

Top module: `pps_cycle_counter`

## Requirements
- R1: While reset is asserted, `sec_valid`, every bit of `dec_valid` and `pps_timeout` are 0, and `sec_count` and every `dec_total` entry are 0.
- R2: `sec_count` equals the number of clock cycles between two consecutive PPS rising edges, taken modulo 2^CNT_W. The counter is not restarted at edges, so consecutive intervals add up to the elapsed time with no gap.
- R3: The first PPS rising edge after reset stores a snapshot only and produces no `sec_valid`.
- R4: A PPS rising edge that the clock first samples at edge c (the input went high after edge c-1) raises `sec_valid` for exactly one cycle, visible after clock edge c+2. Two `sec_valid` pulses are never adjacent.
- R5: Entry k of `dec_total` (k = 0 for the shortest) carries the sum of RATIO^(k+1) consecutive per-second counts. `dec_valid[k]` pulses for one cycle, one clock after the `sec_valid` that completes the interval. The next interval then starts from zero.
- R6: All totals count from the same first per-second sample, so whenever `dec_valid[k]` is 1 for k > 0, `dec_valid[k-1]` is also 1 in the same cycle.
- R7: `pps_timeout` rises TMO_CYC clock cycles after the last internal edge detection, or after reset, if no further edge has been detected. It returns to 0 in the same cycle as the next detection and is never 1 while `sec_valid` is 1.
- R8: A PPS level held high for many cycles is one rising edge and yields at most one `sec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock under test; also the counted clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pps_in | input | 1 | Asynchronous one-pulse-per-second reference |
| sec_count | output | CNT_W | Cycles counted in the last complete second |
| sec_valid | output | 1 | One-cycle strobe for a new `sec_count` |
| dec_total | output | NUM_DEC x TOTAL_W | Totals over RATIO^(k+1) seconds, entry k |
| dec_valid | output | NUM_DEC | One-cycle strobe per total entry |
| pps_timeout | output | 1 | No reference edge within TMO_CYC cycles |

## Verification
A snapshot register that is taken at the wrong moment, or a counter that restarts at an edge, shows up at `sec_count` on the first reported second after the fault. The count is then off by the lost cycles. A tally that is off by one shows up as a `dec_valid` pulse in the wrong cycle at the end of the shortest interval, which is RATIO seconds. A wrong accumulator value shows up in the `dec_total` of that same strobe. The bench model runs cycle by cycle and predicts each strobe to the exact clock, so a latency error of one cycle is reported on the first edge it affects. The same is true of a missing first-edge suppression or a timeout that clears late.

// File: rtl/pps_meas_pkg.sv
// Package: pps_meas_pkg
// Shared helpers for the PPS cycle counter: interval-length arithmetic
// used when elaborating the decade accumulators.
package pps_meas_pkg;

    // Length, in seconds, of decade entry k: ratio raised to (k+1).
    function automatic int unsigned decade_len(input int unsigned ratio, input int unsigned k);
        int unsigned r;
        r = ratio;
        for (int unsigned i = 0; i < k; i++) begin
            r = r * ratio;
        end
        return r;
    endfunction

endpackage

// File: rtl/pps_sync_edge.sv
// Module: pps_sync_edge
// Brings the asynchronous PPS level into the clock domain through a
// SYNC_STAGES-deep flop chain and produces a single-cycle rise pulse.
// Assumes the PPS input stays low for at least two clock cycles between
// pulses; a held-high level gives a single pulse.
module pps_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_async,
    output logic rise_pulse
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the raw level through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], pps_async};
        end
    end

    // Rise seen when the synchronized level is high and its history is low.
    always_comb begin
        rise_pulse = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    end
endmodule

// File: rtl/interval_capture.sv
// Module: interval_capture
// Keeps a free-running cycle counter that is never cleared after reset.
// On each rise pulse it records a snapshot; from the second pulse on it
// reports the modular difference to the previous snapshot. It also keeps
// a saturating cycles-since-edge counter that drives the timeout flag.
// Assumes TMO_CYC >= 2.
module interval_capture #(
    parameter int CNT_W   = 32,
    parameter int TMO_CYC = 75_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic [CNT_W-1:0] sec_count,
    output logic             sec_valid,
    output logic             pps_timeout
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] TMO_SAT  = TW'(TMO_CYC);
    localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] snap_q;
    logic             armed_q;
    logic [TW-1:0]    idle_cnt;

    // Free-running cycle counter; wraps naturally modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_cnt <= '0;
        end else begin
            free_cnt <= free_cnt + 1'b1;
        end
    end

    // Snapshot on each rise and publish the difference once armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q    <= '0;
            armed_q   <= 1'b0;
            sec_count <= '0;
            sec_valid <= 1'b0;
        end else if (rise) begin
            snap_q    <= free_cnt;
            armed_q   <= 1'b1;
            sec_valid <= armed_q;
            if (armed_q) begin
                sec_count <= free_cnt - snap_q;
            end
        end else begin
            sec_valid <= 1'b0;
        end
    end

    // Count idle cycles since the last rise and flag a missing reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt    <= '0;
            pps_timeout <= 1'b0;
        end else if (rise) begin
            idle_cnt    <= '0;
            pps_timeout <= 1'b0;
        end else if (idle_cnt != TMO_SAT) begin
            idle_cnt <= idle_cnt + 1'b1;
            if (idle_cnt == TMO_LAST) begin
                pps_timeout <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/decade_accum.sv
// Module: decade_accum
// Sums LEN consecutive per-second samples into a TOTAL_W accumulator.
// When the LEN-th sample arrives it publishes the total with a one-cycle
// strobe and restarts from zero. Assumes LEN >= 2 and TOTAL_W >= CNT_W.
module decade_accum #(
    parameter int          CNT_W   = 32,
    parameter int          TOTAL_W = 40,
    parameter int unsigned LEN     = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   sample,
    input  logic               sample_valid,
    output logic [TOTAL_W-1:0] total,
    output logic               total_valid
);
    localparam int TLW = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [TLW-1:0] TALLY_LAST = TLW'(LEN - 1);

    logic [TOTAL_W-1:0] acc_q;
    logic [TLW-1:0]     tally_q;
    logic [TOTAL_W-1:0] sample_ext;

    // Zero-extend the per-second sample to the accumulator width.
    always_comb begin
        sample_ext = {{(TOTAL_W - CNT_W){1'b0}}, sample};
    end

    // Accumulate samples; on the last one of the interval, publish and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= '0;
            tally_q     <= '0;
            total       <= '0;
            total_valid <= 1'b0;
        end else if (sample_valid) begin
            if (tally_q == TALLY_LAST) begin
                total       <= acc_q + sample_ext;
                total_valid <= 1'b1;
                acc_q       <= '0;
                tally_q     <= '0;
            end else begin
                acc_q       <= acc_q + sample_ext;
                tally_q     <= tally_q + 1'b1;
                total_valid <= 1'b0;
            end
        end else begin
            total_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pps_cycle_counter.sv
// Module: pps_cycle_counter (top)
// Measures the running clock against a PPS reference with no gate dead
// time. It produces a per-second count and NUM_DEC long-interval totals of
// RATIO^(k+1) seconds each, plus a reference-timeout flag.
// Assumes RATIO >= 2 and that TOTAL_W is wide enough for the longest total.
module pps_cycle_counter #(
    parameter int CNT_W   = 32,
    parameter int TOTAL_W = 40,
    parameter int RATIO   = 10,
    parameter int NUM_DEC = 4,
    parameter int TMO_CYC = 75_000_000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pps_in,
    output logic [CNT_W-1:0]                sec_count,
    output logic                            sec_valid,
    output logic [NUM_DEC-1:0][TOTAL_W-1:0] dec_total,
    output logic [NUM_DEC-1:0]              dec_valid,
    output logic                            pps_timeout
);
    logic pps_rise;

    pps_sync_edge #(
        .SYNC_STAGES (2)
    ) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pps_async  (pps_in),
        .rise_pulse (pps_rise)
    );

    interval_capture #(
        .CNT_W   (CNT_W),
        .TMO_CYC (TMO_CYC)
    ) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (pps_rise),
        .sec_count   (sec_count),
        .sec_valid   (sec_valid),
        .pps_timeout (pps_timeout)
    );

    // One accumulator per decade; all fed from the same per-second samples.
    for (genvar k = 0; k < NUM_DEC; k++) begin : g_dec
        localparam int unsigned LEN_K = pps_meas_pkg::decade_len(RATIO, k);

        decade_accum #(
            .CNT_W   (CNT_W),
            .TOTAL_W (TOTAL_W),
            .LEN     (LEN_K)
        ) acc_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .sample       (sec_count),
            .sample_valid (sec_valid),
            .total        (dec_total[k]),
            .total_valid  (dec_valid[k])
        );
    end
endmodule

// File: rtl/pps_cycle_counter_chk.sv
// Module: pps_cycle_counter_chk
// Port-level protocol checker bound to pps_cycle_counter.
module pps_cycle_counter_chk #(
    parameter int NUM_DEC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sec_valid,
    input logic [NUM_DEC-1:0] dec_valid,
    input logic               pps_timeout
);
    // R4: a per-second strobe lasts one cycle only.
    a_r4_sec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |=> !sec_valid);

    // R7: a fresh edge clears the timeout flag in the cycle it is reported.
    a_r7_timeout_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> !pps_timeout);

    for (genvar k = 0; k < NUM_DEC; k++) begin : g_chk
        // R5: each total strobe follows a per-second strobe by one cycle.
        a_r5_dec_after_sec: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid[k] |-> $past(sec_valid));
        if (k > 0) begin : g_nest
            // R6: a longer interval completes only together with the shorter one.
            a_r6_dec_nested: assert property (@(posedge clk) disable iff (!rst_n)
                dec_valid[k] |-> dec_valid[k-1]);
        end
    end
endmodule

bind pps_cycle_counter pps_cycle_counter_chk #(
    .NUM_DEC (NUM_DEC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_valid   (sec_valid),
    .dec_valid   (dec_valid),
    .pps_timeout (pps_timeout)
);

// File: tb/pps_cycle_counter_tb_top.sv
// Bench: behavioural cycle-accurate model compared at every falling edge.
module pps_cycle_counter_tb_top;
    localparam int CNT_W   = 10;
    localparam int TOTAL_W = 24;
    localparam int RATIO   = 3;
    localparam int NUM_DEC = 4;
    localparam int TMO_CYC = 300;

    logic                            clk = 1'b0;
    logic                            rst_n = 1'b0;
    logic                            pps_in = 1'b0;
    logic [CNT_W-1:0]                sec_count;
    logic                            sec_valid;
    logic [NUM_DEC-1:0][TOTAL_W-1:0] dec_total;
    logic [NUM_DEC-1:0]              dec_valid;
    logic                            pps_timeout;

    pps_cycle_counter #(
        .CNT_W (CNT_W), .TOTAL_W (TOTAL_W), .RATIO (RATIO),
        .NUM_DEC (NUM_DEC), .TMO_CYC (TMO_CYC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .pps_in (pps_in),
        .sec_count (sec_count), .sec_valid (sec_valid),
        .dec_total (dec_total), .dec_valid (dec_valid),
        .pps_timeout (pps_timeout)
    );

    always #4 clk = ~clk;

    int cyc;
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    int     sec_cq[$];
    longint sec_vq[$];
    int     edge_q[$];
    int     dec_cq[NUM_DEC][$];
    longint dec_vq[NUM_DEC][$];
    longint dsum[NUM_DEC];
    int     dn[NUM_DEC];
    int     prev_rise;
    bit     have_prev = 0;
    int     last_edge = 0;
    int     n_checks = 0;
    int     n_fail = 0;
    bit     running = 0;
    bit     done = 0;

    function automatic int dlen(input int k);
        int r = RATIO;
        for (int i = 0; i < k; i++) r = r * RATIO;
        return r;
    endfunction

    function automatic void check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endfunction

    // Model one PPS rise driven just after clock edge c.
    function automatic void model_rise(input int c);
        longint v;
        edge_q.push_back(c + 3);
        if (have_prev) begin
            v = longint'(c - prev_rise) & ((64'sd1 <<< CNT_W) - 1);
            sec_cq.push_back(c + 3);
            sec_vq.push_back(v);
            for (int k = 0; k < NUM_DEC; k++) begin
                dsum[k] += v;
                dn[k]++;
                if (dn[k] == dlen(k)) begin
                    dec_cq[k].push_back(c + 4);
                    dec_vq[k].push_back(dsum[k]);
                    dsum[k] = 0;
                    dn[k] = 0;
                end
            end
        end
        have_prev = 1;
        prev_rise = c;
    endfunction

    // One reference second: period p cycles, high for h cycles. Called at a negedge.
    task automatic one_second(input int p, input int h);
        pps_in = 1'b1;
        model_rise(cyc);
        repeat (h) @(negedge clk);
        pps_in = 1'b0;
        repeat (p - h) @(negedge clk);
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && running && !done) begin
            bit exp_sv;
            bit exp_t;
            while (sec_cq.size() > 0 && sec_cq[0] < cyc) begin
                void'(sec_cq.pop_front());
                void'(sec_vq.pop_front());
            end
            exp_sv = (sec_cq.size() > 0 && sec_cq[0] == cyc);
            check(sec_valid == exp_sv, "R4/R3/R8 sec_valid timing", longint'(sec_valid), longint'(exp_sv));
            if (exp_sv) begin
                check(longint'(sec_count) == sec_vq[0], "R2 per-second count", longint'(sec_count), sec_vq[0]);
                void'(sec_cq.pop_front());
                void'(sec_vq.pop_front());
            end
            while (edge_q.size() > 0 && edge_q[0] <= cyc) last_edge = edge_q.pop_front();
            exp_t = ((cyc - last_edge) >= TMO_CYC);
            check(pps_timeout == exp_t, "R7 timeout flag", longint'(pps_timeout), longint'(exp_t));
            for (int k = 0; k < NUM_DEC; k++) begin
                bit exp_d;
                while (dec_cq[k].size() > 0 && dec_cq[k][0] < cyc) begin
                    void'(dec_cq[k].pop_front());
                    void'(dec_vq[k].pop_front());
                end
                exp_d = (dec_cq[k].size() > 0 && dec_cq[k][0] == cyc);
                check(dec_valid[k] == exp_d, "R5/R6 decade strobe", longint'(dec_valid[k]), longint'(exp_d));
                if (exp_d) begin
                    check(longint'(dec_total[k]) == dec_vq[k][0], "R5 decade total",
                          longint'(dec_total[k]), dec_vq[k][0]);
                    void'(dec_cq[k].pop_front());
                    void'(dec_vq[k].pop_front());
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int c0;
        for (int k = 0; k < NUM_DEC; k++) begin
            dsum[k] = 0;
            dn[k] = 0;
        end
        repeat (5) @(negedge clk);
        // R1: reset state at the ports
        check(sec_valid == 1'b0, "R1 sec_valid in reset", longint'(sec_valid), 0);
        check(dec_valid == '0, "R1 dec_valid in reset", longint'(dec_valid), 0);
        check(pps_timeout == 1'b0, "R1 timeout in reset", longint'(pps_timeout), 0);
        check(sec_count == '0, "R1 sec_count in reset", longint'(sec_count), 0);
        check(dec_total == '0, "R1 dec_total in reset", longint'(dec_total[0]), 0);
        rst_n = 1'b1;
        running = 1;
        repeat (20) @(negedge clk);

        // R3: first edge only arms the snapshot
        pps_in = 1'b1;
        c0 = cyc;
        model_rise(c0);
        repeat (3) @(negedge clk);
        check(sec_valid == 1'b0, "R3 first edge silent", longint'(sec_valid), 0);
        pps_in = 1'b0;
        repeat (47) @(negedge clk);

        // R2: steady seconds, then a +/-1 jittered reference
        for (int i = 0; i < 30; i++) one_second(50, 10);
        for (int i = 0; i < 40; i++) one_second((i % 2 == 1) ? 49 : 51, 5);
        // R8: long high level gives one edge
        one_second(200, 150);
        // R2: varied intervals (counter wraps at 2^CNT_W along the way)
        for (int i = 0; i < 30; i++) one_second(40 + (i * 37) % 120, 3);
        // R7: gap longer than the timeout
        one_second(500, 2);
        for (int i = 0; i < 20; i++) one_second(60, 20);
        repeat (10) @(negedge clk);

        check(sec_cq.size() == 0, "R2 no missed per-second strobe", longint'(sec_cq.size()), 0);
        for (int k = 0; k < NUM_DEC; k++)
            check(dec_cq[k].size() == 0, "R5 no missed decade strobe", longint'(dec_cq[k].size()), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule